// File: doc/BRIEF.md
# Deep-Sleep Exit Delay Sequencer

This block brings a processor out of a deep sleep state. It does this by releasing a chain of five active-high hold strobes in a fixed order. A programmable wait separates each release from the one before it. All waits are counted in pulses of an external one-microsecond tick. A single 8-bit control byte and a separate lock-time input select the wait lengths. The block samples both when an exit request is accepted, so writes made while a sequence is running do not change it.

The hold strobes are the sleep request, the regulator sleep, the CPU stop, the deep sleep and the CPU sleep. An optional slow-exit wait may sit between the sleep-request release and the regulator-sleep release. A stabilisation wait always follows the regulator-sleep release, and the CPU-stop and deep-sleep strobes are released together when it ends. A final lock wait then precedes the CPU-sleep release, which is marked by a one-cycle done pulse. After reset all strobes are held. After a completed exit they stay released until the next request re-holds them and starts again.

Top module: `deep_sleep_exit_seq`

## Requirements
- R1: After reset, all five hold outputs are 1 and `done` is 0, and they stay that way until an exit request is accepted.
- R2: Acceptance of a request:
  - An `exitReq` that is high at a clock edge while no sequence is running starts a sequence.
  - From that edge on, `holdSleepReq` is 0 and `holdCpuStop`, `holdDeepSleep` and `holdCpuSleep` are 1.
  - An `exitReq` that arrives while a sequence is running is ignored, and the running sequence completes with exactly one `done` pulse.
- R3: Slow-exit wait:
  - When `cfgReg[6]` is 1, `holdVrSleep` is released (SLOW_STEP × (`cfgReg[5:4]` + 1)) ticks after the start edge.
  - With the default SLOW_STEP of 8, the codes 00b, 01b, 10b and 11b give 8, 16, 24 and 32 ticks.
  - When `cfgReg[6]` is 0, `holdVrSleep` is released at the start edge itself.
  - In every requirement, a tick count N means the stage ends at the N-th clock edge after its start edge at which `usTick` was high.
- R4: Stabilisation wait: `holdCpuStop` is released a number of ticks after the `holdVrSleep` release that depends on `cfgReg[3:2]`:
  - 00b gives 73 ticks.
  - 01b gives 67 ticks.
  - 10b gives 61 ticks.
  - 11b gives 46 ticks.
- R5: `holdDeepSleep` is released in the same cycle as `holdCpuStop`.
- R6: Lock wait: `holdCpuSleep` is released a number of ticks after the `holdCpuStop` release that depends on `cfgReg[1:0]`:
  - 00b takes the wait from `pllLockUs`.
  - 01b, 10b and 11b give 20, 15 and 10 ticks, overriding `pllLockUs`.
- R7: `done` is high for exactly one cycle, in the cycle where `holdCpuSleep` is released. After that, all hold outputs stay 0 until the next accepted request.
- R8: `cfgReg` and `pllLockUs` are sampled at the start edge, so later changes do not alter the delays of a running sequence.
- R9: `cfgReg[7]` has no effect on any output.
- R10: The release order is fixed:
  - `holdVrSleep` low implies `holdSleepReq` low.
  - `holdCpuStop` low implies `holdVrSleep` low.
  - `holdCpuSleep` low implies `holdCpuStop` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exitReq | input | 1 | Request to start an exit sequence |
| usTick | input | 1 | One-cycle pulse per microsecond |
| cfgReg | input | 8 | Control byte: bit 6 slow enable, 5:4 slow select, 3:2 stabilisation select, 1:0 lock select |
| pllLockUs | input | CNT_W | Lock wait in ticks, used when `cfgReg[1:0]` is 00b |
| holdSleepReq | output | 1 | Sleep-request hold, released first |
| holdVrSleep | output | 1 | Regulator sleep hold |
| holdCpuStop | output | 1 | CPU-stop hold |
| holdDeepSleep | output | 1 | Deep-sleep hold |
| holdCpuSleep | output | 1 | CPU-sleep hold, released last |
| done | output | 1 | One-cycle pulse on completion |

## Verification
The bench walks every code of each select field in directed runs. These runs alternate the slow enable and the reserved bit 7, so a swapped table entry or a misread field position shows up as a wrong tick count. Random runs follow, with irregular tick spacing and random lock times. During these runs the control byte and lock input are rewritten and extra requests are issued mid-sequence. This separates a design that samples its configuration at the start from one that reads it live, and one that ignores requests while busy from one that restarts.

// File: rtl/exit_seq_pkg.sv
package exit_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOW,
    ST_STAB,
    ST_LOCK,
    ST_FIN
  } seqState_t;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_SLOW,
    LD_STAB,
    LD_LOCK
  } loadSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    loadSel_t loadSel;
    logic     latchCfg;
  } ctlStrobe_t;

  localparam int SLOW_EN_BIT = 6;

  function automatic logic [6:0] stabDelay(input logic [1:0] code);
    case (code)
      2'd0:    stabDelay = 7'd73;
      2'd1:    stabDelay = 7'd67;
      2'd2:    stabDelay = 7'd61;
      default: stabDelay = 7'd46;
    endcase
  endfunction

  function automatic logic [6:0] lockDelay(input logic [1:0] code);
    case (code)
      2'd1:    lockDelay = 7'd20;
      2'd2:    lockDelay = 7'd15;
      default: lockDelay = 7'd10;
    endcase
  endfunction

endpackage

// File: rtl/exit_seq_datapath.sv
module exit_seq_datapath
  import exit_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SLOW_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usTick,
  input  logic [7:0]       cfgReg,
  input  logic [CNT_W-1:0] pllLockUs,
  input  ctlStrobe_t       ctl,
  output logic             slowEnLive,
  output logic             stageExpire
);

  logic [5:0]       cfgQ;
  logic [5:0]       cfgView;
  logic [CNT_W-1:0] pllQ;
  logic [CNT_W-1:0] pllView;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             unusedRsvd;

  assign unusedRsvd = cfgReg[7];
  assign slowEnLive = cfgReg[SLOW_EN_BIT];

  // The start edge loads from live inputs; later stages use the sampled copy
  assign cfgView = ctl.latchCfg ? cfgReg[5:0] : cfgQ;
  assign pllView = ctl.latchCfg ? pllLockUs : pllQ;

  always_comb begin
    case (ctl.loadSel)
      LD_SLOW: loadVal = CNT_W'((int'(cfgView[5:4]) + 1) * SLOW_STEP);
      LD_STAB: loadVal = CNT_W'(stabDelay(cfgView[3:2]));
      LD_LOCK: loadVal = (cfgView[1:0] == 2'd0) ? pllView
                                                : CNT_W'(lockDelay(cfgView[1:0]));
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ <= '0;
      pllQ <= '0;
      cnt  <= '0;
    end else begin
      if (ctl.latchCfg) begin
        cfgQ <= cfgReg[5:0];
        pllQ <= pllLockUs;
      end
      if (ctl.loadSel != LD_NONE)
        cnt <= loadVal;
      else if (usTick && cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign stageExpire = (cnt == '0) || (usTick && cnt == CNT_W'(1));

endmodule

// File: rtl/exit_seq_control.sv
module exit_seq_control
  import exit_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exitReq,
  input  logic       slowEnLive,
  input  logic       stageExpire,
  output ctlStrobe_t ctl,
  output logic       holdSleepReq,
  output logic       holdVrSleep,
  output logic       holdCpuStop,
  output logic       holdDeepSleep,
  output logic       holdCpuSleep,
  output logic       done
);

  seqState_t state, stateNext;
  logic      asleep;

  always_comb begin
    stateNext    = state;
    ctl.loadSel  = LD_NONE;
    ctl.latchCfg = 1'b0;
    case (state)
      ST_IDLE: if (exitReq) begin
        ctl.latchCfg = 1'b1;
        if (slowEnLive) begin
          stateNext   = ST_SLOW;
          ctl.loadSel = LD_SLOW;
        end else begin
          stateNext   = ST_STAB;
          ctl.loadSel = LD_STAB;
        end
      end
      ST_SLOW: if (stageExpire) begin
        stateNext   = ST_STAB;
        ctl.loadSel = LD_STAB;
      end
      ST_STAB: if (stageExpire) begin
        stateNext   = ST_LOCK;
        ctl.loadSel = LD_LOCK;
      end
      ST_LOCK: if (stageExpire) stateNext = ST_FIN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      asleep <= 1'b1;
    end else begin
      state <= stateNext;
      if (state == ST_FIN) asleep <= 1'b0;
    end
  end

  always_comb begin
    if (state == ST_IDLE) begin
      holdSleepReq  = asleep;
      holdVrSleep   = asleep;
      holdCpuStop   = asleep;
      holdCpuSleep  = asleep;
    end else begin
      holdSleepReq  = 1'b0;
      holdVrSleep   = (state == ST_SLOW);
      holdCpuStop   = (state == ST_SLOW) || (state == ST_STAB);
      holdCpuSleep  = (state != ST_FIN);
    end
    holdDeepSleep = holdCpuStop;
    done          = (state == ST_FIN);
  end

endmodule

// File: rtl/deep_sleep_exit_seq.sv
module deep_sleep_exit_seq
  import exit_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SLOW_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exitReq,
  input  logic             usTick,
  input  logic [7:0]       cfgReg,
  input  logic [CNT_W-1:0] pllLockUs,
  output logic             holdSleepReq,
  output logic             holdVrSleep,
  output logic             holdCpuStop,
  output logic             holdDeepSleep,
  output logic             holdCpuSleep,
  output logic             done
);

  ctlStrobe_t ctl;
  logic       slowEnLive;
  logic       stageExpire;

  exit_seq_datapath #(.CNT_W(CNT_W), .SLOW_STEP(SLOW_STEP)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .usTick      (usTick),
    .cfgReg      (cfgReg),
    .pllLockUs   (pllLockUs),
    .ctl         (ctl),
    .slowEnLive  (slowEnLive),
    .stageExpire (stageExpire)
  );

  exit_seq_control u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .exitReq       (exitReq),
    .slowEnLive    (slowEnLive),
    .stageExpire   (stageExpire),
    .ctl           (ctl),
    .holdSleepReq  (holdSleepReq),
    .holdVrSleep   (holdVrSleep),
    .holdCpuStop   (holdCpuStop),
    .holdDeepSleep (holdDeepSleep),
    .holdCpuSleep  (holdCpuSleep),
    .done          (done)
  );

endmodule

// File: rtl/exit_seq_checker.sv
module exit_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic usTick,
  input logic holdSleepReq,
  input logic holdVrSleep,
  input logic holdCpuStop,
  input logic holdDeepSleep,
  input logic holdCpuSleep,
  input logic done
);

  AST_VR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !holdVrSleep |-> !holdSleepReq);  // R10

  AST_STOP_AFTER_VR: assert property (@(posedge clk) disable iff (!rst_n)
    !holdCpuStop |-> !holdVrSleep);  // R10

  AST_SLEEP_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !holdCpuSleep |-> !holdCpuStop);  // R10

  AST_DEEP_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    holdDeepSleep == holdCpuStop);  // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!holdCpuSleep && $past(holdCpuSleep)));  // R7

  AST_STAB_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdCpuStop) |-> $past(usTick));  // R4

endmodule

bind deep_sleep_exit_seq exit_seq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .usTick        (usTick),
  .holdSleepReq  (holdSleepReq),
  .holdVrSleep   (holdVrSleep),
  .holdCpuStop   (holdCpuStop),
  .holdDeepSleep (holdDeepSleep),
  .holdCpuSleep  (holdCpuSleep),
  .done          (done)
);

// File: tb/test_deep_sleep_exit_seq.sv
module test_deep_sleep_exit_seq;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             exitReq;
  logic             usTick;
  logic [7:0]       cfgReg;
  logic [CNT_W-1:0] pllLockUs;
  logic holdSleepReq, holdVrSleep, holdCpuStop, holdDeepSleep, holdCpuSleep, done;

  int checks = 0;
  int fails  = 0;

  deep_sleep_exit_seq #(.CNT_W(CNT_W), .SLOW_STEP(8)) i_deep_sleep_exit_seq (
    .clk(clk), .rst_n(rst_n), .exitReq(exitReq), .usTick(usTick),
    .cfgReg(cfgReg), .pllLockUs(pllLockUs),
    .holdSleepReq(holdSleepReq), .holdVrSleep(holdVrSleep),
    .holdCpuStop(holdCpuStop), .holdDeepSleep(holdDeepSleep),
    .holdCpuSleep(holdCpuSleep), .done(done)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int slowTicks(input int code);
    return (code + 1) * 8;
  endfunction

  function automatic int stabTicks(input int code);
    case (code)
      0: return 73;
      1: return 67;
      2: return 61;
      default: return 46;
    endcase
  endfunction

  function automatic int lockTicks(input int code, input int pll);
    case (code)
      0: return pll;
      1: return 20;
      2: return 15;
      default: return 10;
    endcase
  endfunction

  // Monitor state
  bit active = 0;
  bit seqFlag = 0;
  int cyc = 0, cum = 0;
  int startCum, startCyc, vrCum, vrCyc, stopCum, stopCyc, deepCyc, sleepCum, sleepCyc;
  bit gotVr, gotStop, gotDeep, gotSleep;
  int doneCnt;
  int eSlowEn, eSlowCode, eStab, eLock, ePll;

  always begin
    bit t, er;
    logic [7:0] cf;
    logic [CNT_W-1:0] pl;
    @(posedge clk);
    t = usTick; er = exitReq; cf = cfgReg; pl = pllLockUs;
    #2;
    cyc++;
    cum += int'(t);
    if (rst_n) begin
      if (!active && er) begin
        active = 1; startCum = cum; startCyc = cyc;
        gotVr = 0; gotStop = 0; gotDeep = 0; gotSleep = 0; doneCnt = 0;
        eSlowEn = int'(cf[6]); eSlowCode = int'(cf[5:4]);
        eStab = int'(cf[3:2]); eLock = int'(cf[1:0]); ePll = int'(pl);
        // R2: acceptance edge releases the sleep request, later strobes held
        check(!holdSleepReq && holdCpuStop && holdCpuSleep, "R2 start",
              {holdSleepReq, holdCpuStop, holdCpuSleep}, 3'b011);
      end else if (!active && done) begin
        check(0, "R7 stray done", 1, 0);
      end
      if (active) begin
        if (!gotVr && !holdVrSleep) begin gotVr = 1; vrCum = cum; vrCyc = cyc; end
        if (!gotStop && !holdCpuStop) begin gotStop = 1; stopCum = cum; stopCyc = cyc; end
        if (!gotDeep && !holdDeepSleep) begin gotDeep = 1; deepCyc = cyc; end
        if (!gotSleep && !holdCpuSleep) begin gotSleep = 1; sleepCum = cum; sleepCyc = cyc; end
        if (done) begin
          doneCnt++;
          check(gotSleep && sleepCyc == cyc, "R7 done with release", sleepCyc, cyc);
          if (eSlowEn != 0)
            check(vrCum - startCum == slowTicks(eSlowCode), "R3/R8 slow wait",
                  vrCum - startCum, slowTicks(eSlowCode));
          else
            check(vrCyc == startCyc, "R3 no slow wait", vrCyc - startCyc, 0);
          check(stopCum - vrCum == stabTicks(eStab), "R4/R8 stab wait",
                stopCum - vrCum, stabTicks(eStab));
          check(deepCyc == stopCyc, "R5 deep with stop", deepCyc, stopCyc);
          check(sleepCum - stopCum == lockTicks(eLock, ePll), "R6/R8 lock wait",
                sleepCum - stopCum, lockTicks(eLock, ePll));
          check(doneCnt == 1, "R2 single done", doneCnt, 1);
          active = 0;
          seqFlag = 1;
        end
      end
    end
  end

  initial begin
    usTick = 1'b0;
    forever begin
      @(negedge clk);
      usTick = ($urandom % 3) == 0;
    end
  end

  task automatic runSeq(input logic [7:0] cfg, input int pll, input bit perturb);
    @(negedge clk);
    seqFlag = 0;
    cfgReg = cfg;
    pllLockUs = CNT_W'(pll);
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    while (!seqFlag) begin
      @(negedge clk);
      exitReq = 1'b0;
      if (!seqFlag && perturb) begin
        if ($urandom % 20 == 0) cfgReg = 8'($urandom);
        if ($urandom % 20 == 0) pllLockUs = CNT_W'(1 + $urandom % 60);
        if ($urandom % 15 == 0) exitReq = 1'b1;
      end
    end
    repeat (2) @(negedge clk);
    // R7: everything stays released after completion
    check({holdSleepReq, holdVrSleep, holdCpuStop, holdDeepSleep, holdCpuSleep} == 5'b0,
          "R7 stay released",
          {holdSleepReq, holdVrSleep, holdCpuStop, holdDeepSleep, holdCpuSleep}, 0);
  endtask

  initial begin
    void'($urandom(32'd20250601));
    rst_n = 1'b0; exitReq = 1'b0; cfgReg = 8'h00; pllLockUs = CNT_W'(30);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({holdSleepReq, holdVrSleep, holdCpuStop, holdDeepSleep, holdCpuSleep} == 5'h1f,
          "R1 holds after reset",
          {holdSleepReq, holdVrSleep, holdCpuStop, holdDeepSleep, holdCpuSleep}, 31);
    check(done == 1'b0, "R1 done low", int'(done), 0);

    // Directed: every code of each field, slow on and off, bit 7 toggled (R9)
    for (int i = 0; i < 4; i++)
      runSeq({1'b0, 1'b1, 2'(i), 2'(i), 2'(i)}, 30, 0);
    for (int i = 0; i < 4; i++)
      runSeq({1'b1, 1'b0, 2'(i), 2'(3 - i), 2'(i)}, 5 + i, 0);
    runSeq(8'hC0, 1, 0);   // R9 with bit 7, R6 lock from input of one tick
    runSeq(8'h7F, 30, 1);  // R8 perturbed

    // Random runs with mid-sequence writes and ignored requests (R2, R8)
    for (int n = 0; n < 24; n++)
      runSeq(8'($urandom), 1 + int'($urandom % 60), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule